// File: doc/BRIEF.md
# Privilege-Gated Interrupt Selector

This block decides each clock cycle which local interrupt a hart should take, if any. It forms the candidate set from the pending and enable vectors. It gates each candidate by privilege: delegated candidates pass only when supervisor-level interrupts are open, and the rest pass only when machine-level interrupts are open. From the survivors it picks the one with the lowest bit index. The decision is registered, so it appears one clock after the inputs that produced it.

When virtualization is active, the three guest-supervisor sources are kept apart from the others. At bit positions 2, 6 and 10 sit software, timer and external. First, all other candidates are gated by the host-supervisor enable. If any survive, the lowest of them wins and a force-to-host flag is raised. Only if none survive do the guest sources go through the normal delegation gating. When virtualization is off, the guest sources are never taken.

Standard bit positions apply to the other sources. Supervisor and machine software are 1 and 3, timers are 5 and 7, and external interrupts are 9 and 11. Privilege is encoded U=0, S=1, M=3. The value 2 counts as below M and above S.

Top module: `irq_priv_selector`

## Requirements
- R1: While reset is asserted (rstN low), and in the first cycle after it, takeIrq, forceHs and causeNum are all 0, whatever the inputs.
- R2: Only bits set in both pendVec and enableVec are candidates; a pending bit whose enable is 0 is never taken.
- R3: Non-delegated candidates (delegVec bit 0) are open when privLvl is below 3, or when privLvl is 3 and mGlobalEn is 1; at privLvl 3 with mGlobalEn 0 nothing is taken.
- R4: Delegated candidates (delegVec bit 1) are open when privLvl is 0, or when privLvl is 1 and sGlobalEn is 1; at privLvl 2 or 3 they are never taken.
- R5: Delegated and non-delegated candidates are gated independently. A blocked delegated bit does not stop an open non-delegated bit from being taken, and the reverse also holds.
- R6: Among surviving candidates the lowest bit index is chosen, and causeNum carries that index as an unsigned number.
- R7: When no candidate survives, takeIrq is 0, causeNum is 0 and forceHs is 0.
- R8: With virtOn 1, non-guest candidates are taken first, with delegation ignored, when privLvl is 0, or privLvl is 1 and hsSGlobalEn is 1. The lowest such bit wins and forceHs is 1.
- R9: With virtOn 1 and no candidate taken under R8, only guest bits 2, 6 and 10 go on to the R3/R4 gating, and forceHs is 0.
- R10: With virtOn 0, guest bits 2, 6 and 10 are never taken, even when pending, enabled and open.
- R11: Outputs change only at a rising clock edge. They reflect the inputs present at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_IRQ | Pending interrupt bits |
| enableVec | input | NUM_IRQ | Per-bit interrupt enables |
| delegVec | input | NUM_IRQ | Delegation mask, 1 = handled at supervisor level |
| privLvl | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| mGlobalEn | input | 1 | Machine-level global interrupt enable |
| sGlobalEn | input | 1 | Supervisor-level global interrupt enable |
| virtOn | input | 1 | Virtualization active |
| hsSGlobalEn | input | 1 | Host-supervisor global interrupt enable used while virtualized |
| takeIrq | output | 1 | An interrupt is to be taken |
| causeNum | output | CAUSE_W | Index of the selected interrupt |
| forceHs | output | 1 | Selected interrupt goes to the host supervisor level |

## Verification
Every result of this block (take flag, cause and force flag) is due exactly one rising edge after the inputs that decide it. There is no deeper pipeline and no dependence on earlier decisions. The bench therefore drives inputs on the falling edge and computes the expected triple from those inputs alone. It compares the outputs on the following falling edge, after exactly one rising edge has gone by. One check also samples just after a new drive, before the edge, to confirm that the previous result still stands.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } privLvl_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic mOpen;      // non-delegated candidates may pass
    logic sOpen;      // delegated candidates may pass
    logic hsOpen;     // host-level pass while virtualized
    logic virtSplit;  // guest sources handled in a second phase
  } gateStrobes_t;

endpackage

// File: rtl/irqsel_lowpick.sv
module irqsel_lowpick #(
  parameter int NUM_IRQ = 16,
  parameter int CAUSE_W = 6
) (
  input  logic [NUM_IRQ-1:0] vecIn,
  output logic               found,
  output logic [CAUSE_W-1:0] idx
);

  logic [NUM_IRQ:0]   seenChain;
  logic [NUM_IRQ-1:0] winHot;

  assign seenChain[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : gChain
      assign seenChain[g+1] = seenChain[g] | vecIn[g];
      assign winHot[g]      = vecIn[g] & ~seenChain[g];
    end
  endgenerate

  assign found = seenChain[NUM_IRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (winHot[i]) idx = idx | CAUSE_W'(i);
    end
  end

endmodule

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl
  import irqsel_pkg::*;
(
  input  logic [1:0]   privLvl,
  input  logic         mGlobalEn,
  input  logic         sGlobalEn,
  input  logic         virtOn,
  input  logic         hsSGlobalEn,
  output gateStrobes_t strobes
);

  logic belowM, belowS, atM, atS;

  assign belowM = (privLvl != PRIV_M);
  assign belowS = (privLvl == PRIV_U);
  assign atM    = (privLvl == PRIV_M);
  assign atS    = (privLvl == PRIV_S);

  always_comb begin
    strobes.mOpen     = belowM | (atM & mGlobalEn);
    strobes.sOpen     = belowS | (atS & sGlobalEn);
    strobes.hsOpen    = belowS | (atS & hsSGlobalEn);
    strobes.virtSplit = virtOn;
  end

  // R4: supervisor-level opening implies machine-level opening at every level.
  always_comb begin
    a_s_implies_m_r4: assert (!strobes.sOpen || strobes.mOpen);
  end

endmodule

// File: rtl/irqsel_datapath.sv
module irqsel_datapath
  import irqsel_pkg::*;
#(
  parameter int                 NUM_IRQ = 16,
  parameter int                 CAUSE_W = 6,
  parameter logic [NUM_IRQ-1:0] VS_MASK = NUM_IRQ'(16'h0444)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegVec,
  input  logic [1:0]         privLvl,
  input  logic               mGlobalEn,
  input  logic               virtOn,
  input  gateStrobes_t       strobes,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] causeNum,
  output logic               forceHs
);

  logic [NUM_IRQ-1:0] candVec, hostCand, guestCand, hsPool, phase2Pool, gatedVec;
  logic               hsFound, mainFound;
  logic [CAUSE_W-1:0] hsIdx, mainIdx;
  logic               takeNext, forceNext;
  logic [CAUSE_W-1:0] causeNext;

  assign candVec   = pendVec & enableVec;
  assign hostCand  = candVec & ~VS_MASK;
  assign guestCand = candVec & VS_MASK;

  assign hsPool     = (strobes.virtSplit && strobes.hsOpen) ? hostCand : '0;
  assign phase2Pool = strobes.virtSplit ? guestCand : hostCand;
  assign gatedVec   = (phase2Pool & ~delegVec & {NUM_IRQ{strobes.mOpen}})
                    | (phase2Pool &  delegVec & {NUM_IRQ{strobes.sOpen}});

  irqsel_lowpick #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W)) i_pickHs (
    .vecIn(hsPool), .found(hsFound), .idx(hsIdx)
  );

  irqsel_lowpick #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W)) i_pickMain (
    .vecIn(gatedVec), .found(mainFound), .idx(mainIdx)
  );

  always_comb begin
    takeNext  = 1'b0;
    forceNext = 1'b0;
    causeNext = '0;
    if (hsFound) begin
      takeNext  = 1'b1;
      forceNext = 1'b1;
      causeNext = hsIdx;
    end else if (mainFound) begin
      takeNext  = 1'b1;
      causeNext = mainIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq  <= 1'b0;
      forceHs  <= 1'b0;
      causeNum <= '0;
    end else begin
      takeIrq  <= takeNext;
      forceHs  <= forceNext;
      causeNum <= causeNext;
    end
  end

  // R2: a taken cause was pending and enabled at the deciding edge.
  p_cause_candidate_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ((($past(pendVec & enableVec)) >> causeNum) & NUM_IRQ'(1)) != '0);

  // R7: idle output carries a zero cause and no force.
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (causeNum == '0) && !forceHs);

  // R8: force only comes with a take while virtualized.
  p_force_virt_r8: assert property (@(posedge clk) disable iff (!rstN)
    forceHs |-> takeIrq && $past(virtOn));

  // R10: guest sources are hidden without virtualization.
  p_guest_hidden_r10: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && !$past(virtOn)) |-> ((VS_MASK >> causeNum) & NUM_IRQ'(1)) == '0);

  // R3: machine level with global enable clear takes nothing.
  p_mmode_closed_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(privLvl == PRIV_M && !mGlobalEn) |-> !takeIrq);

endmodule

// File: rtl/irq_priv_selector.sv
module irq_priv_selector
  import irqsel_pkg::*;
#(
  parameter int                 NUM_IRQ = 16,
  parameter int                 CAUSE_W = 6,
  parameter logic [NUM_IRQ-1:0] VS_MASK = NUM_IRQ'(16'h0444)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] pendVec,
  input  logic [NUM_IRQ-1:0] enableVec,
  input  logic [NUM_IRQ-1:0] delegVec,
  input  logic [1:0]         privLvl,
  input  logic               mGlobalEn,
  input  logic               sGlobalEn,
  input  logic               virtOn,
  input  logic               hsSGlobalEn,
  output logic               takeIrq,
  output logic [CAUSE_W-1:0] causeNum,
  output logic               forceHs
);

  gateStrobes_t strobes;

  irqsel_ctrl i_ctrl (
    .privLvl    (privLvl),
    .mGlobalEn  (mGlobalEn),
    .sGlobalEn  (sGlobalEn),
    .virtOn     (virtOn),
    .hsSGlobalEn(hsSGlobalEn),
    .strobes    (strobes)
  );

  irqsel_datapath #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W), .VS_MASK(VS_MASK)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pendVec  (pendVec),
    .enableVec(enableVec),
    .delegVec (delegVec),
    .privLvl  (privLvl),
    .mGlobalEn(mGlobalEn),
    .virtOn   (virtOn),
    .strobes  (strobes),
    .takeIrq  (takeIrq),
    .causeNum (causeNum),
    .forceHs  (forceHs)
  );

endmodule

// File: tb/test_irq_priv_selector.sv
`timescale 1ns/1ps
module test_irq_priv_selector;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pendVec = '0, enableVec = '0, delegVec = '0;
  logic [1:0]   privLvl = 2'd0;
  logic         mGlobalEn = 1'b0, sGlobalEn = 1'b0, virtOn = 1'b0, hsSGlobalEn = 1'b0;
  logic         takeIrq, forceHs;
  logic [5:0]   causeNum;

  int  checks = 0;
  int  errors = 0;
  bit  summaryDone = 0;
  bit  expTake, expForce;
  int  expCause;

  always #2 clk = ~clk;

  irq_priv_selector i_irq_priv_selector (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enableVec(enableVec),
    .delegVec(delegVec), .privLvl(privLvl), .mGlobalEn(mGlobalEn),
    .sGlobalEn(sGlobalEn), .virtOn(virtOn), .hsSGlobalEn(hsSGlobalEn),
    .takeIrq(takeIrq), .causeNum(causeNum), .forceHs(forceHs)
  );

  function automatic bit isGuest(int b);
    return (b == 2) || (b == 6) || (b == 10);
  endfunction

  // Behavioural reference of the selection rules.
  task automatic computeExpected();
    int  lvl;
    bit  mOk, sOk, hsOk;
    lvl = int'(privLvl);
    mOk  = (lvl < 3) || (lvl == 3 && mGlobalEn);
    sOk  = (lvl < 1) || (lvl == 1 && sGlobalEn);
    hsOk = (lvl < 1) || (lvl == 1 && hsSGlobalEn);
    expTake = 0; expForce = 0; expCause = 0;
    if (virtOn && hsOk) begin
      for (int b = 0; b < N; b++) begin
        if (!expTake && pendVec[b] && enableVec[b] && !isGuest(b)) begin
          expTake = 1; expForce = 1; expCause = b;
        end
      end
    end
    if (!expTake) begin
      for (int b = 0; b < N; b++) begin
        if (!expTake && pendVec[b] && enableVec[b] && (isGuest(b) == virtOn)
            && (delegVec[b] ? sOk : mOk)) begin
          expTake = 1; expCause = b;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (takeIrq !== expTake || forceHs !== expForce || int'(causeNum) != expCause) begin
      errors++;
      $display("FAIL %s: take=%b cause=%0d force=%b expected take=%b cause=%0d force=%b",
               tag, takeIrq, causeNum, forceHs, expTake, expCause, expForce);
    end
  endtask

  task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
                       input logic [1:0] pl, input bit me, input bit se, input bit v,
                       input bit hs, input string tag);
    pendVec = p; enableVec = e; delegVec = d; privLvl = pl;
    mGlobalEn = me; sGlobalEn = se; virtOn = v; hsSGlobalEn = hs;
    computeExpected();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    bit hTake, hForce;
    int hCause;
    // R1: reset holds outputs low even with an open interrupt present.
    pendVec = 16'h0800; enableVec = 16'h0800; privLvl = 2'd0;
    repeat (3) @(negedge clk);
    expTake = 0; expForce = 0; expCause = 0;
    compare("R1 during reset");
    rstN = 1'b1;
    pendVec = '0; enableVec = '0;
    @(posedge clk); @(negedge clk);
    compare("R1 after reset");

    // R2
    apply(16'h0200, 16'h0000, 16'h0, 2'd0, 1, 1, 0, 0, "R2 pending not enabled");
    apply(16'h0220, 16'h0200, 16'h0, 2'd0, 1, 1, 0, 0, "R2 only enabled bit");
    // R3
    apply(16'h0800, 16'h0800, 16'h0, 2'd3, 1, 0, 0, 0, "R3 M mode enabled");
    apply(16'h0800, 16'h0800, 16'h0, 2'd3, 0, 1, 0, 0, "R3 M mode disabled");
    apply(16'h0080, 16'h0080, 16'h0, 2'd1, 0, 0, 0, 0, "R3 below M");
    apply(16'h0080, 16'h0080, 16'h0, 2'd2, 0, 0, 0, 0, "R3 level 2 below M");
    // R4
    apply(16'h0020, 16'h0020, 16'h0020, 2'd1, 1, 0, 0, 0, "R4 S closed");
    apply(16'h0020, 16'h0020, 16'h0020, 2'd1, 1, 1, 0, 0, "R4 S open");
    apply(16'h0020, 16'h0020, 16'h0020, 2'd0, 0, 0, 0, 0, "R4 U below S");
    apply(16'h0002, 16'h0002, 16'h0002, 2'd3, 1, 1, 0, 0, "R4 M blocks delegated");
    apply(16'h0002, 16'h0002, 16'h0002, 2'd2, 1, 1, 0, 0, "R4 level 2 blocks delegated");
    // R5
    apply(16'h0202, 16'hFFFF, 16'h0002, 2'd1, 1, 0, 0, 0, "R5 delegated blocked, other taken");
    apply(16'h0822, 16'hFFFF, 16'h0002, 2'd3, 0, 1, 0, 0, "R5 both closed in M");
    // R6
    apply(16'h0888, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R6 lowest of 3,7,11");
    apply(16'h0220, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R6 lowest of 5,9");
    apply(16'h8001, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R6 bit 0 wins");
    apply(16'h8000, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R6 top bit");
    // R7
    apply(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 0, "R7 nothing pending");
    // R8
    apply(16'h0204, 16'hFFFF, 16'h0, 2'd1, 1, 1, 1, 1, "R8 host first with force");
    apply(16'h0202, 16'hFFFF, 16'h0202, 2'd0, 0, 0, 1, 0, "R8 U virtualized");
    apply(16'h0800, 16'hFFFF, 16'h0, 2'd1, 0, 0, 1, 1, "R8 ignores M gating");
    // R9
    apply(16'h0240, 16'hFFFF, 16'h0040, 2'd1, 1, 1, 1, 0, "R9 guest after host closed");
    apply(16'h0240, 16'hFFFF, 16'h0040, 2'd1, 1, 0, 1, 0, "R9 guest delegated closed");
    apply(16'h0400, 16'hFFFF, 16'h0, 2'd1, 0, 0, 1, 0, "R9 guest non-delegated below M");
    apply(16'h0200, 16'hFFFF, 16'h0, 2'd1, 1, 1, 1, 0, "R9 host bit never in phase 2");
    // R10
    apply(16'h0444, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 1, "R10 guest bits hidden");
    apply(16'h0446, 16'hFFFF, 16'h0, 2'd0, 1, 1, 0, 1, "R10 host bit among guests");

    // R11: new inputs do not show before the edge.
    apply(16'h0008, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R11 setup");
    hTake = expTake; hForce = expForce; hCause = expCause;
    pendVec = 16'h0100;
    #1;
    expTake = hTake; expForce = hForce; expCause = hCause;
    compare("R11 holds before edge");
    computeExpected();
    @(posedge clk); @(negedge clk);
    compare("R11 after edge");

    // Mixed stimulus, every rule against the model.
    for (int k = 0; k < 3000; k++) begin
      apply(N'($urandom), N'($urandom), N'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R6 R8 R9 mixed");
    end

    finishRun();
  end

endmodule